// File: doc/BRIEF.md
# Mirrored Two-Plane Memory Controller

This block sits between a host and two synchronous RAM planes of the same size, a main plane and a backup plane. In mirrored operation every accepted host write lands in both planes, so the backup plane always holds a copy of the main plane. Host reads are always served from the main plane.

When a checkpoint is requested, the backup plane is cut off from the host and becomes a frozen, read-only image that an archiving agent reads through its own checkpoint read port. The host keeps writing during this time. Its writes update only the main plane, and each one is also queued as an address/value pair in a log FIFO. Once the archiving agent reports that it is finished, the controller drains the log into the backup plane, one entry per cycle and in arrival order. Host writes that arrive during the drain are appended to the same log. When the log is empty and no write is arriving, the planes match again and mirrored operation resumes. If the log fills, the host is held off through a ready signal, and any write attempted while held off sets a sticky flag.

Top module: `mirror_plane_ctrl`

## Requirements
- R1: After synchronous reset, `mode` is 0 (mirror), `host_wr_ready` is 1, `log_stall_seen` is 0, and both read-data outputs are 0.
- R2: In mirror mode (`mode`=0), an accepted host write updates the same address in both planes, so a later checkpoint image holds the written value.
- R3: A host read with `host_rd_en` high at a clock edge returns the main-plane word on `host_rd_data` after that edge. The output holds until the next read. A write to the same address on the same edge is not yet visible to that read.
- R4: `mode` encodes 0 = mirror, 1 = checkpoint, 2 = catch-up and changes on the edge where its condition is sampled. `ckpt_start` moves mirror to checkpoint and has no effect in any other mode.
- R5: While `mode` is 1 the backup plane takes no writes. A checkpoint read returns, one cycle after `ckpt_rd_en`, the backup word as it stood when the checkpoint began.
- R6: In modes 1 and 2, each accepted host write goes to the main plane only and is appended to the log. `host_wr_ready` is 0 exactly when the mode is not mirror and the log holds `LOG_DEPTH` entries. Writes made while ready is 0 are dropped.
- R7: In mode 2, one log entry per cycle is written into the backup plane in arrival order. The mode returns to 0 on the first edge where the log is empty and no write is accepted, after which the backup plane equals the main plane.
- R8: `log_stall_seen` becomes 1 on the edge after `host_wr_en` is high while `host_wr_ready` is 0, and stays 1 until reset.
- R9: `ckpt_done` moves checkpoint to catch-up and has no effect in mirror or catch-up mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write request |
| host_wr_addr | input | ADDR_W | Host write address |
| host_wr_data | input | DATA_W | Host write value |
| host_wr_ready | output | 1 | Host write can be accepted this cycle |
| host_rd_en | input | 1 | Host read request |
| host_rd_addr | input | ADDR_W | Host read address |
| host_rd_data | output | DATA_W | Main-plane read result, one cycle later |
| ckpt_start | input | 1 | Request to freeze the backup plane |
| ckpt_done | input | 1 | Archiving agent has finished reading |
| ckpt_rd_en | input | 1 | Checkpoint read request |
| ckpt_rd_addr | input | ADDR_W | Checkpoint read address |
| ckpt_rd_data | output | DATA_W | Backup-plane read result, one cycle later |
| mode | output | 2 | 0 mirror, 1 checkpoint, 2 catch-up |
| log_stall_seen | output | 1 | Sticky: a write was attempted while held off |

## Verification
Every result of this block appears exactly one edge after the inputs that cause it. Mode changes, the stall flag and both read outputs update on the edge that samples their inputs, and ready reflects the state left by the previous edge. The bench drives inputs after the falling edge and lets a behavioural model step on the rising edge. It compares all five outputs at the next falling edge, so every comparison is made one full register stage after its cause. Catch-up correctness is judged by a second checkpoint read-out, which must match the model's main plane word for word.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

    typedef enum logic [1:0] {
        MODE_MIRROR  = 2'd0,
        MODE_CKPT    = 2'd1,
        MODE_CATCHUP = 2'd2
    } mode_e;

    // Next mode from the current one and the sampled controls.
    function automatic mode_e next_mode(
        input mode_e cur,
        input logic  start,
        input logic  done,
        input logic  log_empty,
        input logic  log_push
    );
        mode_e nxt;
        nxt = cur;
        unique case (cur)
            MODE_MIRROR:  if (start)                   nxt = MODE_CKPT;
            MODE_CKPT:    if (done)                    nxt = MODE_CATCHUP;
            MODE_CATCHUP: if (log_empty && !log_push)  nxt = MODE_MIRROR;
            default:                                   nxt = MODE_MIRROR;
        endcase
        return nxt;
    endfunction

    function automatic logic needs_log(input mode_e cur);
        return cur != MODE_MIRROR;
    endfunction

endpackage

// File: rtl/mpm_ram.sv
module mpm_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Read-first: a same-edge write is not seen by the read.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/mpm_log_fifo.sv
module mpm_log_fifo #(
    parameter int WIDTH = 20,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign dout  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    AST_FIFO_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) full |-> !push);  // R6
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) empty |-> !pop);  // R7
endmodule

// File: rtl/mpm_ctrl.sv
module mpm_ctrl
    import mpm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ckpt_start,
    input  logic  ckpt_done,
    input  logic  log_empty,
    input  logic  log_push,
    output mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_MIRROR;
        end else begin
            mode <= next_mode(mode, ckpt_start, ckpt_done, log_empty, log_push);
        end
    end

    AST_MODE_LEGAL:      assert property (@(posedge clk) disable iff (rst) mode != 2'd3);  // R4
    AST_NO_REENTER_CKPT: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CATCHUP) |=> (mode != MODE_CKPT));  // R4
    AST_DONE_IN_MIRROR:  assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_MIRROR && !ckpt_start) |=> (mode == MODE_MIRROR));  // R9
    AST_EXIT_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CATCHUP && !log_empty) |=> (mode == MODE_CATCHUP));  // R7
endmodule

// File: rtl/mirror_plane_ctrl.sv
module mirror_plane_ctrl
    import mpm_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int LOG_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    output logic              host_wr_ready,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              ckpt_start,
    input  logic              ckpt_done,
    input  logic              ckpt_rd_en,
    input  logic [ADDR_W-1:0] ckpt_rd_addr,
    output logic [DATA_W-1:0] ckpt_rd_data,
    output logic [1:0]        mode,
    output logic              log_stall_seen
);
    localparam int ENTRY_W = ADDR_W + DATA_W;

    mode_e              cur_mode;
    logic               log_empty, log_full;
    logic               wr_accept, log_push, log_pop;
    logic [ENTRY_W-1:0] log_head;
    logic               bk_we;
    logic [ADDR_W-1:0]  bk_waddr;
    logic [DATA_W-1:0]  bk_wdata;

    assign host_wr_ready = !(needs_log(cur_mode) && log_full);
    assign wr_accept     = host_wr_en && host_wr_ready;
    assign log_push      = wr_accept && needs_log(cur_mode);
    assign log_pop       = (cur_mode == MODE_CATCHUP) && !log_empty;
    assign mode          = cur_mode;

    // Backup plane write source: host in mirror mode, log head in catch-up.
    always_comb begin
        bk_we    = 1'b0;
        bk_waddr = host_wr_addr;
        bk_wdata = host_wr_data;
        if (cur_mode == MODE_MIRROR) begin
            bk_we = wr_accept;
        end else if (log_pop) begin
            bk_we    = 1'b1;
            bk_waddr = log_head[ENTRY_W-1:DATA_W];
            bk_wdata = log_head[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            log_stall_seen <= 1'b0;
        end else if (host_wr_en && !host_wr_ready) begin
            log_stall_seen <= 1'b1;
        end
    end

    mpm_ctrl i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ckpt_start (ckpt_start),
        .ckpt_done  (ckpt_done),
        .log_empty  (log_empty),
        .log_push   (log_push),
        .mode       (cur_mode)
    );

    mpm_log_fifo #(.WIDTH(ENTRY_W), .DEPTH(LOG_DEPTH)) i_log (
        .clk   (clk),
        .rst   (rst),
        .push  (log_push),
        .din   ({host_wr_addr, host_wr_data}),
        .pop   (log_pop),
        .dout  (log_head),
        .empty (log_empty),
        .full  (log_full)
    );

    mpm_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_main (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_accept),
        .waddr (host_wr_addr),
        .wdata (host_wr_data),
        .re    (host_rd_en),
        .raddr (host_rd_addr),
        .rdata (host_rd_data)
    );

    mpm_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_backup (
        .clk   (clk),
        .rst   (rst),
        .we    (bk_we),
        .waddr (bk_waddr),
        .wdata (bk_wdata),
        .re    (ckpt_rd_en),
        .raddr (ckpt_rd_addr),
        .rdata (ckpt_rd_data)
    );

    AST_BACKUP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_CKPT) |-> !bk_we);  // R5
    AST_MIRROR_BOTH:   assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_MIRROR && host_wr_en) |-> (bk_we && host_wr_ready));  // R2
    AST_STALL_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (cur_mode != MODE_MIRROR && log_full) |-> !host_wr_ready);  // R6
    AST_STALL_STICKY:  assert property (@(posedge clk) disable iff (rst)
        log_stall_seen |=> log_stall_seen);  // R8
endmodule

// File: tb/test_mirror_plane_ctrl.sv
`timescale 1ns/1ps
module test_mirror_plane_ctrl;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int LD = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 0, rd_en = 0, start = 0, done = 0, ck_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, ck_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          ready, stall_seen;
    logic [DW-1:0] rd_data, ck_data;
    logic [1:0]    mode;

    always #2.5 clk = ~clk;

    mirror_plane_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LOG_DEPTH(LD)) i_mirror_plane_ctrl (
        .clk(clk), .rst(rst),
        .host_wr_en(wr_en), .host_wr_addr(wr_addr), .host_wr_data(wr_data),
        .host_wr_ready(ready),
        .host_rd_en(rd_en), .host_rd_addr(rd_addr), .host_rd_data(rd_data),
        .ckpt_start(start), .ckpt_done(done),
        .ckpt_rd_en(ck_en), .ckpt_rd_addr(ck_addr), .ckpt_rd_data(ck_data),
        .mode(mode), .log_stall_seen(stall_seen)
    );

    // Behavioural reference model
    logic [DW-1:0] m_main [WORDS];
    logic [DW-1:0] m_bk   [WORDS];
    logic [AW-1:0] q_addr [$];
    logic [DW-1:0] q_data [$];
    int            m_mode;
    logic [DW-1:0] e_rd, e_ck;
    logic          e_stall;
    logic          m_rdy, m_acc, m_empty0;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;

    function automatic logic model_ready();
        return !(m_mode != 0 && q_addr.size() == LD);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; e_rd = '0; e_ck = '0; e_stall = 1'b0;
            q_addr.delete(); q_data.delete();
        end else begin
            m_rdy = model_ready();
            m_acc = wr_en && m_rdy;
            if (rd_en) e_rd = m_main[rd_addr];
            if (ck_en) e_ck = m_bk[ck_addr];
            if (wr_en && !m_rdy) e_stall = 1'b1;
            case (m_mode)
                0: begin
                    if (m_acc) begin m_main[wr_addr] = wr_data; m_bk[wr_addr] = wr_data; end
                    if (start) m_mode = 1;
                end
                1: begin
                    if (m_acc) begin
                        m_main[wr_addr] = wr_data;
                        q_addr.push_back(wr_addr); q_data.push_back(wr_data);
                    end
                    if (done) m_mode = 2;
                end
                default: begin
                    m_empty0 = (q_addr.size() == 0);
                    if (!m_empty0) begin
                        pa = q_addr.pop_front(); pd = q_data.pop_front();
                        m_bk[pa] = pd;
                    end
                    if (m_acc) begin
                        m_main[wr_addr] = wr_data;
                        q_addr.push_back(wr_addr); q_data.push_back(wr_data);
                    end
                    if (m_empty0 && !m_acc) m_mode = 0;
                end
            endcase
        end
    end

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string ck_tag   = "R5";

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R4 mode", 32'(mode), 32'(m_mode));
        check("R6 ready", 32'(ready), 32'(model_ready()));
        check("R8 stall flag", 32'(stall_seen), 32'(e_stall));
        check("R3 host read", 32'(rd_data), 32'(e_rd));
        check(ck_tag, 32'(ck_data), 32'(e_ck));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        wr_en = 0; rd_en = 0; start = 0; done = 0; ck_en = 0;
    endtask

    task automatic host_wr(input int a, input int d);
        wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    endtask

    task automatic host_rd(input int a);
        rd_en = 1; rd_addr = AW'(a);
    endtask

    task automatic ckpt_rd(input int a);
        ck_en = 1; ck_addr = AW'(a);
    endtask

    task automatic drain();
        for (int k = 0; k < 100 && m_mode != 0; k++) begin
            host_rd(k % WORDS);
            cyc();
        end
        check("R7 back to mirror", 32'(mode), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1 mode", 32'(mode), 32'd0);
        check("R1 ready", 32'(ready), 32'd1);
        check("R1 stall flag", 32'(stall_seen), 32'd0);
        check("R1 host read", 32'(rd_data), 32'd0);
        check("R1 ckpt read", 32'(ck_data), 32'd0);

        // R2: mirrored fill of every word
        for (int a = 0; a < WORDS; a++) begin
            host_wr(a, a * 37 + 5);
            cyc();
        end
        // R3: reads, including read-first on a colliding write
        for (int a = 0; a < WORDS; a++) begin
            host_rd(a);
            if (a % 4 == 0) host_wr(a, 16'hA000 + a);
            cyc();
        end
        // R9: done in mirror mode has no effect
        done = 1;
        cyc();
        check("R9 done ignored in mirror", 32'(mode), 32'd0);

        // Start a checkpoint; read the frozen image while the host writes (R2, R5)
        ck_tag = "R2 R5 checkpoint image";
        start = 1;
        cyc();
        check("R4 entered checkpoint", 32'(mode), 32'd1);
        for (int a = 0; a < WORDS; a++) begin
            ckpt_rd(a);
            if (a < 5) host_wr(WORDS - 1 - a, 16'h5500 + a);
            if (a == 3) start = 1;
            if (a == 7) host_rd(WORDS - 1);
            cyc();
        end
        check("R4 start ignored in checkpoint", 32'(mode), 32'd1);

        // R6, R8: fill the log until the host is held off
        for (int k = 0; k < 6; k++) begin
            host_wr(k * 3 % WORDS, 16'h6600 + k);
            cyc();
        end
        check("R6 ready low when log full", 32'(ready), 32'd0);
        host_wr(2, 16'hDEAD);
        cyc();
        check("R8 stall flag set", 32'(stall_seen), 32'd1);
        host_rd(2);
        cyc();

        // R9, R7: finish; keep writing during catch-up; start ignored (R4)
        done = 1;
        cyc();
        check("R9 done moves to catch-up", 32'(mode), 32'd2);
        for (int k = 0; k < 5; k++) begin
            host_wr(k + 8, 16'h7700 + k);
            if (k == 1) start = 1;
            cyc();
        end
        check("R4 start ignored in catch-up", 32'(mode), 32'd2);
        drain();
        check("R8 flag still set", 32'(stall_seen), 32'd1);

        // R7: second checkpoint image must equal the main plane
        ck_tag = "R7 backup caught up";
        start = 1;
        cyc();
        for (int a = 0; a < WORDS; a++) begin
            ckpt_rd(a);
            cyc();
            check("R7 image equals main", 32'(ck_data), 32'(m_main[a]));
        end
        done = 1;
        cyc();
        drain();

        // R2 in mirror again, then verify through another checkpoint
        ck_tag = "R2 mirrored write";
        host_wr(6, 16'hBEEF);
        cyc();
        start = 1;
        cyc();
        ckpt_rd(6);
        cyc();
        check("R2 backup holds mirrored write", 32'(ck_data), 32'hBEEF);
        done = 1;
        cyc();
        drain();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule